// File: doc/BRIEF.md
# Addressing-mode operand fetch sequencer

This block fetches a single source operand for a 16-bit-bus processor core. On a `start` pulse it captures the addressing mode, the register number, the operand size, the extension word at the head of the prefetch queue, the address of the current instruction and a snapshot of the sixteen-entry register file. It then works out the effective address and issues the bus microcycles that the mode needs, strictly in order: idle cycles, program prefetches and data reads.

When the last microcycle finishes, the block returns the operand and the effective address on a one-cycle `done` pulse. If the mode changes an address register, it also returns the updated value for that register.

A bus controller serves the microcycles through a valid/acknowledge handshake and may insert any number of wait cycles. The same controller returns the next instruction-stream word on `busData` after a prefetch, and the memory word after a data read. Register direct, address register direct and quick operands need no bus traffic at all.

Top module: `opfetch_seq`

## Requirements
- R1: Mode codes 0 (data register direct), 1 (address register direct) and 2 (quick) issue no microcycle. They raise `done` one cycle after `start`, and `operand` carries the full 32-bit data register, the full 32-bit address register or `quickVal` respectively, whatever the size.
- R2: Mode 3 (indirect) and mode 4 (postincrement) read at the address register value. Postincrement then writes back that value plus the step: 1 for byte, 2 for word, 4 for long. A byte step on register 7 is 2.
- R3: Mode 5 (predecrement) first subtracts the same step from the address register, then issues one idle microcycle, then the read or reads at the decremented address. The decremented value is written back.
- R4: Mode 6 (displacement) and mode 8 (program-relative displacement) issue one prefetch and then the read. The address is the base plus the sign-extended 16-bit extension word. The base is the address register for mode 6 and `instrAddr`+2 for mode 8.
- R5: Mode 7 (indexed) and mode 9 (program-relative indexed) issue one idle microcycle, one prefetch, and then the read. The address is the base plus the index plus the sign-extended extension bits 7:0. Extension bits 15:12 choose the index register (values 0-7 are data registers, 8-15 are address registers). Extension bit 11 set selects the full 32-bit index; clear selects the sign-extended low 16 bits.
- R6: Mode 10 (absolute short) issues one prefetch and reads at the sign-extended extension word. Mode 11 (absolute long) issues two prefetches and reads at {extension word, word returned by the first prefetch}.
- R7: Mode 12 (immediate) issues one prefetch for byte or word and returns the extension word zero-extended (byte: bits 7:0 only). For long it issues two prefetches and returns {extension word, word returned by the first prefetch}.
- R8: A long data operand is read as two words: the high word at the effective address, then the low word at the effective address + 2. A byte read keeps `busData` bits 7:0, zero-extended. A word read is zero-extended.
- R9: Each microcycle holds `busValid` high with a stable `busKind` (1 idle, 2 prefetch, 3 data read) until `busAck` is seen high at a rising edge. A microcycle completes at that edge. `done` is high for exactly the one cycle after the final completion.
- R10: After reset `busValid` and `done` are low. A `start` asserted while a fetch is in progress is ignored.
- R11: `anWrEn` is raised together with `done` only for postincrement and predecrement. At that point `anWrIdx` names the address register and `anWrData` carries its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch; inputs below are captured in this cycle |
| mode | input | 4 | Addressing mode code (0-12) |
| regNum | input | 3 | Register number of the operand |
| opSize | input | 2 | 0 byte, 1 word, 2 long |
| extWord | input | 16 | Extension word at the head of the prefetch queue |
| instrAddr | input | 32 | Address of the current instruction |
| quickVal | input | 32 | Value supplied for a quick operand |
| regFile | input | 512 | Registers 0-15 (data 0-7, address 8-15), 32 bits each, register n at bits 32n+31:32n |
| busValid | output | 1 | Microcycle requested |
| busKind | output | 2 | 1 idle, 2 prefetch, 3 data read |
| busAddr | output | 32 | Data-read address |
| busAck | input | 1 | Microcycle completes at this edge |
| busData | input | 16 | Prefetched word or read data |
| done | output | 1 | Operand and address valid |
| operand | output | 32 | Fetched operand |
| effAddr | output | 32 | Effective address of a memory operand |
| anWrEn | output | 1 | Address register update valid |
| anWrIdx | output | 3 | Address register to update |
| anWrData | output | 32 | New address register value |

## Verification
Every mode is driven in turn, and the sizes are varied within a mode. This separates the step table (a byte step of 1 against 2 on register 7) and the split into a high and a low read for long operands. Indexed fetches use a data register whose low half is negative, once with the short index and once with the long index, plus an address-register index. This tells apart the sign extension of the index, the register bank selection and the 8-bit displacement. The bus model inserts 0 to 2 wait cycles in rotation, so a held request is distinct from a repeated one. One absolute-long fetch keeps `start` high for several cycles to show that a request made while busy has no effect on the microcycle stream or the result.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
  localparam int WORD_W    = 16;
  localparam int LONG_W    = 2 * WORD_W;
  localparam int REG_SEL_W = 3;
  localparam int NUM_REGS  = 2 ** (REG_SEL_W + 1);
  localparam int RF_W      = NUM_REGS * LONG_W;

  typedef enum logic [3:0] {
    M_DREG    = 4'd0,
    M_AREG    = 4'd1,
    M_QUICK   = 4'd2,
    M_IND     = 4'd3,
    M_POSTINC = 4'd4,
    M_PREDEC  = 4'd5,
    M_DISP    = 4'd6,
    M_INDEX   = 4'd7,
    M_PCDISP  = 4'd8,
    M_PCINDEX = 4'd9,
    M_ABSS    = 4'd10,
    M_ABSL    = 4'd11,
    M_IMM     = 4'd12
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } opsize_e;

  typedef enum logic [1:0] {
    MC_NONE = 2'd0,
    MC_IDLE = 2'd1,
    MC_PREF = 2'd2,
    MC_READ = 2'd3
  } mcyc_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldIn;     // capture inputs, compute start address
    logic ldAbsL;   // form absolute long address from queue
    logic ldImmL;   // form long immediate from queue
    logic ldHi;     // store high word of a long read
    logic ldLo;     // store final read word
    logic selOff2;  // address second word of a long
    logic fin;      // fetch complete
  } dpCtl_t;
endpackage

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  amode_e mode,
  input  logic   isLongIn,
  input  logic   busAck,
  output logic   busValid,
  output mcyc_e  busKind,
  output dpCtl_t ctl
);
  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_PFA, S_PFB, S_RDH, S_RDL
  } st_e;

  st_e    st, stNext;
  amode_e modeQ;
  logic   longQ;

  function automatic st_e firstRead(input logic lng);
    return lng ? S_RDH : S_RDL;
  endfunction

  always_comb begin
    stNext   = st;
    ctl      = '0;
    busValid = 1'b0;
    busKind  = MC_NONE;
    unique case (st)
      S_IDLE: begin
        if (start) begin
          ctl.ldIn = 1'b1;
          unique case (mode)
            M_IND, M_POSTINC:           stNext = firstRead(isLongIn);
            M_PREDEC, M_INDEX, M_PCINDEX: stNext = S_GAP;
            M_DISP, M_PCDISP, M_ABSS, M_ABSL, M_IMM: stNext = S_PFA;
            default:                    ctl.fin = 1'b1;
          endcase
        end
      end
      S_GAP: begin
        busValid = 1'b1;
        busKind  = MC_IDLE;
        if (busAck) stNext = (modeQ == M_PREDEC) ? firstRead(longQ) : S_PFA;
      end
      S_PFA: begin
        busValid = 1'b1;
        busKind  = MC_PREF;
        if (busAck) begin
          if (modeQ == M_ABSL) begin
            ctl.ldAbsL = 1'b1;
            stNext     = S_PFB;
          end else if (modeQ == M_IMM) begin
            if (longQ) begin
              ctl.ldImmL = 1'b1;
              stNext     = S_PFB;
            end else begin
              ctl.fin = 1'b1;
              stNext  = S_IDLE;
            end
          end else begin
            stNext = firstRead(longQ);
          end
        end
      end
      S_PFB: begin
        busValid = 1'b1;
        busKind  = MC_PREF;
        if (busAck) begin
          if (modeQ == M_ABSL) stNext = firstRead(longQ);
          else begin
            ctl.fin = 1'b1;
            stNext  = S_IDLE;
          end
        end
      end
      S_RDH: begin
        busValid = 1'b1;
        busKind  = MC_READ;
        if (busAck) begin
          ctl.ldHi = 1'b1;
          stNext   = S_RDL;
        end
      end
      S_RDL: begin
        busValid    = 1'b1;
        busKind     = MC_READ;
        ctl.selOff2 = longQ;
        if (busAck) begin
          ctl.ldLo = 1'b1;
          ctl.fin  = 1'b1;
          stNext   = S_IDLE;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      modeQ <= M_DREG;
      longQ <= 1'b0;
    end else begin
      st <= stNext;
      if (ctl.ldIn) begin
        modeQ <= mode;
        longQ <= isLongIn;
      end
    end
  end

  // R9: an unacknowledged request stays up with the same kind
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busAck) |=> (busValid && $stable(busKind)));

  // R8: the high-word read is always followed by the low-word read
  a_r8_hi_then_lo: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_RDH && busAck) |=> (st == S_RDL && busValid && ctl.selOff2));
endmodule

// File: rtl/opfetch_dpath.sv
module opfetch_dpath
  import opfetch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  amode_e               mode,
  input  logic [REG_SEL_W-1:0] regNum,
  input  opsize_e              opSize,
  input  logic [WORD_W-1:0]    extWord,
  input  logic [LONG_W-1:0]    instrAddr,
  input  logic [LONG_W-1:0]    quickVal,
  input  logic [RF_W-1:0]      regFile,
  input  logic [WORD_W-1:0]    busData,
  output logic [LONG_W-1:0]    busAddr,
  output logic                 done,
  output logic [LONG_W-1:0]    operand,
  output logic [LONG_W-1:0]    effAddr,
  output logic                 anWrEn,
  output logic [REG_SEL_W-1:0] anWrIdx,
  output logic [LONG_W-1:0]    anWrData
);
  logic [LONG_W-1:0] rf [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rf
    assign rf[g] = regFile[g*LONG_W +: LONG_W];
  end

  logic [LONG_W-1:0] anVal, step, idxRaw, idxVal, disp16, disp8, pcBase;
  logic [LONG_W-1:0] eaStart, opStart, anNext;

  assign anVal  = rf[{1'b1, regNum}];
  assign idxRaw = rf[extWord[WORD_W-1 -: REG_SEL_W+1]];
  assign idxVal = extWord[11] ? idxRaw : {{WORD_W{idxRaw[WORD_W-1]}}, idxRaw[WORD_W-1:0]};
  assign disp16 = {{WORD_W{extWord[WORD_W-1]}}, extWord};
  assign disp8  = {{(LONG_W-8){extWord[7]}}, extWord[7:0]};
  assign pcBase = instrAddr + LONG_W'(2);

  always_comb begin
    unique case (opSize)
      SZ_BYTE: step = (regNum == '1) ? LONG_W'(2) : LONG_W'(1);
      SZ_WORD: step = LONG_W'(2);
      default: step = LONG_W'(4);
    endcase
  end

  always_comb begin
    eaStart = anVal;
    anNext  = anVal;
    unique case (mode)
      M_POSTINC: anNext  = anVal + step;
      M_PREDEC: begin
        anNext  = anVal - step;
        eaStart = anVal - step;
      end
      M_DISP:    eaStart = anVal + disp16;
      M_PCDISP:  eaStart = pcBase + disp16;
      M_INDEX:   eaStart = anVal + idxVal + disp8;
      M_PCINDEX: eaStart = pcBase + idxVal + disp8;
      M_ABSS:    eaStart = disp16;
      default:   eaStart = anVal;
    endcase
  end

  always_comb begin
    unique case (mode)
      M_DREG:  opStart = rf[{1'b0, regNum}];
      M_AREG:  opStart = anVal;
      M_QUICK: opStart = quickVal;
      M_IMM:   opStart = (opSize == SZ_BYTE) ? {{(LONG_W-8){1'b0}}, extWord[7:0]}
                                             : {{WORD_W{1'b0}}, extWord};
      default: opStart = '0;
    endcase
  end

  amode_e               modeQ;
  opsize_e              sizeQ;
  logic [WORD_W-1:0]    extQ;
  logic [REG_SEL_W-1:0] regQ;
  logic [LONG_W-1:0]    eaQ, opQ, anNewQ;
  logic                 doneQ, wrQ;
  amode_e               curMode;

  assign curMode = ctl.ldIn ? mode : modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= M_DREG;
      sizeQ  <= SZ_BYTE;
      extQ   <= '0;
      regQ   <= '0;
      eaQ    <= '0;
      opQ    <= '0;
      anNewQ <= '0;
      doneQ  <= 1'b0;
      wrQ    <= 1'b0;
    end else begin
      if (ctl.ldIn) begin
        modeQ  <= mode;
        sizeQ  <= opSize;
        extQ   <= extWord;
        regQ   <= regNum;
        eaQ    <= eaStart;
        opQ    <= opStart;
        anNewQ <= anNext;
      end
      if (ctl.ldAbsL) eaQ <= {extQ, busData};
      if (ctl.ldImmL) opQ <= {extQ, busData};
      if (ctl.ldHi)   opQ[LONG_W-1:WORD_W] <= busData;
      if (ctl.ldLo) begin
        unique case (sizeQ)
          SZ_BYTE: opQ <= {{(LONG_W-8){1'b0}}, busData[7:0]};
          SZ_WORD: opQ <= {{WORD_W{1'b0}}, busData};
          default: opQ <= {opQ[LONG_W-1:WORD_W], busData};
        endcase
      end
      doneQ <= ctl.fin;
      wrQ   <= ctl.fin && (curMode == M_POSTINC || curMode == M_PREDEC);
    end
  end

  assign busAddr  = ctl.selOff2 ? eaQ + LONG_W'(2) : eaQ;
  assign done     = doneQ;
  assign operand  = opQ;
  assign effAddr  = eaQ;
  assign anWrEn   = wrQ;
  assign anWrIdx  = regQ;
  assign anWrData = anNewQ;

  // R11: register update only accompanies completion
  a_r11_wr_with_done: assert property (@(posedge clk) disable iff (!rstN)
    anWrEn |-> done);

  // R3: predecrement reads where the register now points
  a_r3_predec_ea: assert property (@(posedge clk) disable iff (!rstN)
    (anWrEn && modeQ == M_PREDEC) |-> (effAddr == anWrData));

  // R2: postincrement advances by a legal step past the address used
  a_r2_postinc_step: assert property (@(posedge clk) disable iff (!rstN)
    (anWrEn && modeQ == M_POSTINC) |->
      ((anWrData - effAddr) == 1 || (anWrData - effAddr) == 2 || (anWrData - effAddr) == 4));
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           mode,
  input  logic [REG_SEL_W-1:0] regNum,
  input  logic [1:0]           opSize,
  input  logic [WORD_W-1:0]    extWord,
  input  logic [LONG_W-1:0]    instrAddr,
  input  logic [LONG_W-1:0]    quickVal,
  input  logic [RF_W-1:0]      regFile,
  output logic                 busValid,
  output logic [1:0]           busKind,
  output logic [LONG_W-1:0]    busAddr,
  input  logic                 busAck,
  input  logic [WORD_W-1:0]    busData,
  output logic                 done,
  output logic [LONG_W-1:0]    operand,
  output logic [LONG_W-1:0]    effAddr,
  output logic                 anWrEn,
  output logic [REG_SEL_W-1:0] anWrIdx,
  output logic [LONG_W-1:0]    anWrData
);
  dpCtl_t  ctl;
  mcyc_e   kind;
  amode_e  modeE;
  opsize_e sizeE;

  assign modeE   = amode_e'(mode);
  assign sizeE   = opsize_e'(opSize);
  assign busKind = kind;

  opfetch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mode     (modeE),
    .isLongIn (sizeE == SZ_LONG),
    .busAck   (busAck),
    .busValid (busValid),
    .busKind  (kind),
    .ctl      (ctl)
  );

  opfetch_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .mode      (modeE),
    .regNum    (regNum),
    .opSize    (sizeE),
    .extWord   (extWord),
    .instrAddr (instrAddr),
    .quickVal  (quickVal),
    .regFile   (regFile),
    .busData   (busData),
    .busAddr   (busAddr),
    .done      (done),
    .operand   (operand),
    .effAddr   (effAddr),
    .anWrEn    (anWrEn),
    .anWrIdx   (anWrIdx),
    .anWrData  (anWrData)
  );

  // R9: completion leaves the bus quiet in that cycle
  a_r9_quiet_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busValid);
endmodule

// File: tb/opfetch_seq_tb.sv
module opfetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  regNum = '0;
  logic [1:0]  opSize = '0;
  logic [15:0] extWord = '0;
  logic [31:0] instrAddr = 32'h0000_4000;
  logic [31:0] quickVal = 32'hFFFF_FFFD;
  logic [511:0] regFile;
  logic        busValid, busAck = 1'b0;
  logic [1:0]  busKind;
  logic [31:0] busAddr;
  logic [15:0] busData = '0;
  logic        done, anWrEn;
  logic [31:0] operand, effAddr, anWrData;
  logic [2:0]  anWrIdx;

  logic [31:0] benchRegs [16];
  int checks = 0, fails = 0;
  int expN = 0, expPos = 0;
  logic [1:0]  expKind [8];
  logic [31:0] expAddr [8];
  int waitLeft = 0, ackSeed = 0, pfNext = 16'h0700, cycles = 0;
  bit expectDone = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < 16; i++) regFile[i*32 +: 32] = benchRegs[i];

  opfetch_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .regNum(regNum),
    .opSize(opSize), .extWord(extWord), .instrAddr(instrAddr), .quickVal(quickVal),
    .regFile(regFile), .busValid(busValid), .busKind(busKind), .busAddr(busAddr),
    .busAck(busAck), .busData(busData), .done(done), .operand(operand),
    .effAddr(effAddr), .anWrEn(anWrEn), .anWrIdx(anWrIdx), .anWrData(anWrData)
  );

  function automatic logic [15:0] memWord(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic addExp(input logic [1:0] k, input logic [31:0] a);
    expKind[expN] = k;
    expAddr[expN] = a;
    expN++;
  endtask

  // Bus model: rotating wait states, checks each microcycle as it is acknowledged
  always @(negedge clk) begin
    if (rstN) begin
      if (done && !expectDone) begin
        checks++; fails++;
        $display("FAIL R9 unexpected done: actual 1 expected 0");
      end
      if (busValid) begin
        if (waitLeft > 0) begin
          waitLeft--;
          busAck = 1'b0;
        end else begin
          busAck = 1'b1;
          if (expPos >= expN) chk("R9 extra microcycle", 32'(expPos), 32'(expN));
          else begin
            chk("R9 microcycle kind", {30'd0, busKind}, {30'd0, expKind[expPos]});
            if (busKind == 2'd3) chk("R8 read address", busAddr, expAddr[expPos]);
            expPos++;
          end
          if (busKind == 2'd2) begin
            busData = pfNext[15:0];
            pfNext++;
          end else begin
            busData = memWord(busAddr);
          end
          waitLeft = ackSeed % 3;
          ackSeed++;
        end
      end else begin
        busAck = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic runVec(input string tag, input logic [3:0] m, input logic [2:0] r,
                        input logic [1:0] sz, input logic [15:0] ext, input bit holdStart);
    logic [31:0] an, stp, ea, expOp, wr, x, base;
    logic [15:0] p0, w0, w1;
    bit doRead, expWr;
    int cyc, nHold;
    an = benchRegs[8 + r];
    stp = (sz == 2'd0) ? ((r == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1) ? 32'd2 : 32'd4;
    expN = 0; expPos = 0; doRead = 0; expWr = 0;
    ea = '0; expOp = '0; wr = '0;
    p0 = pfNext[15:0];
    case (m)
      4'd0: expOp = benchRegs[r];
      4'd1: expOp = an;
      4'd2: expOp = quickVal;
      4'd3: begin ea = an; doRead = 1; end
      4'd4: begin ea = an; doRead = 1; expWr = 1; wr = an + stp; end
      4'd5: begin ea = an - stp; addExp(2'd1, 0); doRead = 1; expWr = 1; wr = ea; end
      4'd6: begin addExp(2'd2, 0); ea = an + {{16{ext[15]}}, ext}; doRead = 1; end
      4'd8: begin addExp(2'd2, 0); ea = instrAddr + 2 + {{16{ext[15]}}, ext}; doRead = 1; end
      4'd7, 4'd9: begin
        addExp(2'd1, 0); addExp(2'd2, 0);
        base = (m == 4'd7) ? an : instrAddr + 2;
        x = benchRegs[ext[15:12]];
        if (!ext[11]) x = {{16{x[15]}}, x[15:0]};
        ea = base + x + {{24{ext[7]}}, ext[7:0]};
        doRead = 1;
      end
      4'd10: begin addExp(2'd2, 0); ea = {{16{ext[15]}}, ext}; doRead = 1; end
      4'd11: begin addExp(2'd2, 0); addExp(2'd2, 0); ea = {ext, p0}; doRead = 1; end
      default: begin
        addExp(2'd2, 0);
        if (sz == 2'd2) begin addExp(2'd2, 0); expOp = {ext, p0}; end
        else if (sz == 2'd0) expOp = {24'd0, ext[7:0]};
        else expOp = {16'd0, ext};
      end
    endcase
    if (doRead) begin
      w0 = memWord(ea);
      w1 = memWord(ea + 2);
      if (sz == 2'd2) begin
        addExp(2'd3, ea); addExp(2'd3, ea + 2);
        expOp = {w0, w1};
      end else begin
        addExp(2'd3, ea);
        expOp = (sz == 2'd0) ? {24'd0, w0[7:0]} : {16'd0, w0};
      end
    end
    expectDone = 1'b1;
    mode = m; regNum = r; opSize = sz; extWord = ext; start = 1'b1;
    nHold = holdStart ? 4 : 1;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc >= nHold) start = 1'b0;
      if (done) break;
      if (cyc > 300) begin
        chk({tag, " done timeout"}, 32'd0, 32'd1);
        break;
      end
    end
    chk({tag, " operand"}, operand, expOp);
    if (m >= 4'd3 && m != 4'd12) chk({tag, " effective address"}, effAddr, ea);
    chk({tag, " R9 microcycle count"}, 32'(expPos), 32'(expN));
    chk({tag, " R11 update enable"}, {31'd0, anWrEn}, {31'd0, expWr});
    if (expWr) begin
      chk({tag, " R11 update index"}, {29'd0, anWrIdx}, {29'd0, r});
      chk({tag, " R11 update value"}, anWrData, wr);
    end
    @(negedge clk);
    expectDone = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) benchRegs[i] = 32'h0000_1000 * (i + 1) + 32'(i * 4);
    benchRegs[3] = 32'h0002_FFF0;
    repeat (3) @(negedge clk);
    chk("R10 reset busValid", {31'd0, busValid}, 32'd0);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    runVec("R1 data direct", 4'd0, 3'd2, 2'd2, 16'h0000, 0);
    runVec("R1 addr direct", 4'd1, 3'd5, 2'd1, 16'h0000, 0);
    runVec("R1 quick", 4'd2, 3'd0, 2'd0, 16'h0000, 0);
    runVec("R2 indirect word", 4'd3, 3'd1, 2'd1, 16'h0000, 0);
    runVec("R8 indirect long", 4'd3, 3'd1, 2'd2, 16'h0000, 0);
    runVec("R2 postinc byte", 4'd4, 3'd2, 2'd0, 16'h0000, 0);
    runVec("R2 postinc byte A7", 4'd4, 3'd7, 2'd0, 16'h0000, 0);
    runVec("R2 postinc long", 4'd4, 3'd3, 2'd2, 16'h0000, 0);
    runVec("R3 predec word", 4'd5, 3'd4, 2'd1, 16'h0000, 0);
    runVec("R3 predec byte A7", 4'd5, 3'd7, 2'd0, 16'h0000, 0);
    runVec("R3 predec long", 4'd5, 3'd0, 2'd2, 16'h0000, 0);
    runVec("R4 displacement", 4'd6, 3'd1, 2'd1, 16'hFFF0, 0);
    runVec("R4 pc displacement long", 4'd8, 3'd0, 2'd2, 16'h0100, 0);
    runVec("R5 index short D", 4'd7, 3'd2, 2'd1, 16'h30FC, 0);
    runVec("R5 index long D", 4'd7, 3'd2, 2'd1, 16'h38FC, 0);
    runVec("R5 index A byte", 4'd7, 3'd6, 2'd0, 16'hA004, 0);
    runVec("R5 pc index long", 4'd9, 3'd0, 2'd2, 16'h1810, 0);
    runVec("R6 absolute short", 4'd10, 3'd0, 2'd1, 16'h8002, 0);
    runVec("R6 absolute long", 4'd11, 3'd0, 2'd2, 16'h0003, 0);
    runVec("R10 start held while busy", 4'd11, 3'd0, 2'd2, 16'h0001, 1);
    runVec("R7 immediate byte", 4'd12, 3'd0, 2'd0, 16'h12AB, 0);
    runVec("R7 immediate word", 4'd12, 3'd0, 2'd1, 16'h9234, 0);
    runVec("R7 immediate long", 4'd12, 3'd0, 2'd2, 16'hCAFE, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule